// File: doc/BRIEF.md
# Width-Grouped Physical Register Allocator

This block hands out free physical registers to the rename stage of an out-of-order core whose register file is split into three width groups: narrow, mid and wide. Group membership follows the register index. Two boundary inputs cut the index space into three contiguous ranges, so the split can be moved at run time by whatever logic resizes the groups. Each rename request carries a predicted width group. The block grants the lowest-index free register of that group in the same cycle. When that group is empty, it either spills into a wider group or refuses the request, depending on a stall-mode input. Either way it raises a miss event naming the group that ran short.

The block also serves writeback. When a result turns out wider than the register it was given, writeback presents the old tag and the group the value actually needs. The allocator first looks in that group and then in the group one step wider. If it finds a register, it broadcasts the old and new tags so that waiting consumers can retarget, and it frees the old register at the same edge. If it finds none, it asks for a pipeline flush and changes nothing. Commit returns one register per cycle through a release port.

Top module: `wgra_alloc`

## Requirements
- R1: After reset every register is free and no grant, broadcast, flush or miss is driven while no request, recovery or release is presented.
- R2: Group codes are 0 narrow, 1 mid, 2 wide, and 3 is treated as wide. Index i belongs to group 0 when i < bound_lo, to group 1 when bound_lo <= i < bound_hi, and to group 2 otherwise. A request whose group has a free register is granted the lowest free index of that group, combinationally and in the same cycle, with grant_grp equal to the requested group and no miss.
- R3: With stall_mode=0, a request whose group is empty is granted the lowest free index of the nearest wider group that has one. grant_grp names that group, and miss_valid=1 with miss_grp equal to the requested group.
- R4: With stall_mode=1, a request whose group is empty is not granted. req_stall=1 and a miss event is raised for the requested group.
- R5: A request for which neither its group nor any wider group has a free register is not granted, and req_stall=1 with a miss event for the requested group.
- R6: A recovery (wb_under_valid=1) takes the lowest free index of the needed group, or failing that of the group exactly one step wider. It drives bcast_valid=1, bcast_new_tag with that index, and bcast_old_tag equal to wb_old_tag.
- R7: The old register of a successful recovery becomes free at the same edge at which the new one is taken.
- R8: A recovery that finds no register in the needed group or the next wider group drives flush_req=1 and bcast_valid=0, and leaves every register's state unchanged, including the old tag. A group two steps wider is not searched.
- R9: A request in the same cycle as a recovery is not served. It sees req_stall=1, grant_valid=0 and miss_valid=0.
- R10: rel_valid with rel_tag frees that register from the next cycle. One release per cycle is accepted, and releases on consecutive cycles each take effect.
- R11: A recovery that needs the wide group searches only the wide group and requests a flush when that group is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall_mode | input | 1 | 1: refuse requests whose group is empty instead of spilling wider |
| bound_lo | input | 9 | First index of the mid group |
| bound_hi | input | 9 | First index of the wide group |
| req_valid | input | 1 | Rename request present |
| req_grp | input | 2 | Predicted width group of the request |
| grant_valid | output | 1 | Register granted this cycle |
| grant_tag | output | 8 | Granted register index |
| grant_grp | output | 2 | Group the granted register came from |
| req_stall | output | 1 | Request present but not served |
| miss_valid | output | 1 | Requested group had no free register |
| miss_grp | output | 2 | Group that missed |
| wb_under_valid | input | 1 | Writeback underprediction recovery present |
| wb_old_tag | input | 8 | Register that proved too narrow |
| wb_need_grp | input | 2 | Group wide enough for the actual value |
| bcast_valid | output | 1 | Replacement found; tags broadcast |
| bcast_old_tag | output | 8 | Tag being replaced |
| bcast_new_tag | output | 8 | Replacement tag |
| flush_req | output | 1 | No replacement; pipeline flush requested |
| rel_valid | input | 1 | Commit release present |
| rel_tag | input | 8 | Register returned at commit |

## Verification
Requests are driven with the requested group free, with the requested group empty and the next group free, and with the requested group and the next group both empty while the wide group still has room. This separates the in-group path from the nearest-wider spill. The same empty-group pattern is repeated with stall_mode set to tell fallback from refusal. Recoveries are tried with the needed group free, with only the next wider group free, and with only a group two steps wider free. The last case shows that the search stops one step up and ends in a flush. The wide group is then exhausted to cover the full-file refusal and the wide-only recovery. Follow-up requests reveal whether old tags were freed or left in place, and a request made alongside a recovery shows the priority.

// File: rtl/wgra_pkg.sv
// Package: shared group codes for the width-grouped register allocator.
// Assumes three groups ordered narrow < mid < wide by index range.
package wgra_pkg;
    typedef enum logic [1:0] {
        GRP_NARROW = 2'd0,
        GRP_MID    = 2'd1,
        GRP_WIDE   = 2'd2
    } grp_e;

    localparam int unsigned NUM_GRP = 3;

    // Map the spare code onto the wide group.
    function automatic logic [1:0] grp_clamp(input logic [1:0] g);
        return (g == 2'd3) ? 2'(GRP_WIDE) : g;
    endfunction
endpackage

// File: rtl/wgra_group_mask.sv
// Module: builds the membership mask of one width group from the two
// run-time boundaries. Assumes bound_lo <= bound_hi <= NUM_REGS.
module wgra_group_mask #(
    parameter int unsigned NUM_REGS = 256,
    parameter int unsigned GRP      = 0,
    localparam int unsigned BW      = $clog2(NUM_REGS + 1)
) (
    input  logic [BW-1:0]       bound_lo,
    input  logic [BW-1:0]       bound_hi,
    output logic [NUM_REGS-1:0] mask
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_bit
        localparam logic [BW-1:0] IDX = BW'(i);
        if (GRP == 0) begin : g_narrow
            // Narrow group: below the lower boundary.
            assign mask[i] = (IDX < bound_lo);
        end else if (GRP == 1) begin : g_mid
            // Mid group: between the two boundaries.
            assign mask[i] = (IDX >= bound_lo) && (IDX < bound_hi);
        end else begin : g_wide
            // Wide group: at or above the upper boundary.
            assign mask[i] = (IDX >= bound_hi);
        end
    end
endmodule

// File: rtl/wgra_lowest_pick.sv
// Module: finds the lowest set bit of a vector. Purely combinational.
module wgra_lowest_pick #(
    parameter int unsigned N  = 256,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top so that the lowest set bit is written last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/wgra_free_vec.sv
// Module: free bit per physical register. One take and two returns per
// cycle; a return wins over a take of the same index. All free at reset.
module wgra_free_vec #(
    parameter int unsigned NUM_REGS = 256,
    localparam int unsigned IW      = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take_valid,
    input  logic [IW-1:0]       take_idx,
    input  logic                ret_a_valid,
    input  logic [IW-1:0]       ret_a_idx,
    input  logic                ret_b_valid,
    input  logic [IW-1:0]       ret_b_idx,
    output logic [NUM_REGS-1:0] free
);
    logic [NUM_REGS-1:0] free_nxt;

    // Apply the take, then the returns.
    always_comb begin
        free_nxt = free;
        if (take_valid)  free_nxt[take_idx]  = 1'b0;
        if (ret_a_valid) free_nxt[ret_a_idx] = 1'b1;
        if (ret_b_valid) free_nxt[ret_b_idx] = 1'b1;
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) free <= '1;
        else        free <= free_nxt;
    end
endmodule

// File: rtl/wgra_alloc.sv
// Module: width-grouped physical register allocator (top). Grants the
// lowest free register of the predicted group, spills to a wider group or
// stalls, resolves writeback underpredictions with a same-group / next-wider
// / flush sequence, and frees one register per cycle at commit.
// Assumes bound_lo <= bound_hi and that released tags are allocated.
module wgra_alloc
    import wgra_pkg::*;
#(
    parameter int unsigned NUM_REGS = 256,
    localparam int unsigned IW      = $clog2(NUM_REGS),
    localparam int unsigned BW      = $clog2(NUM_REGS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stall_mode,
    input  logic [BW-1:0] bound_lo,
    input  logic [BW-1:0] bound_hi,
    input  logic          req_valid,
    input  logic [1:0]    req_grp,
    output logic          grant_valid,
    output logic [IW-1:0] grant_tag,
    output logic [1:0]    grant_grp,
    output logic          req_stall,
    output logic          miss_valid,
    output logic [1:0]    miss_grp,
    input  logic          wb_under_valid,
    input  logic [IW-1:0] wb_old_tag,
    input  logic [1:0]    wb_need_grp,
    output logic          bcast_valid,
    output logic [IW-1:0] bcast_old_tag,
    output logic [IW-1:0] bcast_new_tag,
    output logic          flush_req,
    input  logic          rel_valid,
    input  logic [IW-1:0] rel_tag
);
    logic [NUM_REGS-1:0] free;
    logic [NUM_REGS-1:0] grp_mask [NUM_GRP];
    logic [NUM_GRP-1:0]  grp_found;
    logic [IW-1:0]       grp_idx  [NUM_GRP];
    logic [1:0]          req_eff;
    logic [1:0]          need_eff;
    logic [1:0]          need_up;

    // One mask and one lowest-free picker per group.
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic [NUM_REGS-1:0] avail;
        wgra_group_mask #(.NUM_REGS(NUM_REGS), .GRP(g)) u_mask (
            .bound_lo (bound_lo),
            .bound_hi (bound_hi),
            .mask     (grp_mask[g])
        );
        assign avail = free & grp_mask[g];
        wgra_lowest_pick #(.N(NUM_REGS)) u_pick (
            .vec   (avail),
            .found (grp_found[g]),
            .idx   (grp_idx[g])
        );
    end

    assign req_eff       = grp_clamp(req_grp);
    assign need_eff      = grp_clamp(wb_need_grp);
    assign need_up       = (need_eff == 2'(GRP_WIDE)) ? 2'(GRP_WIDE) : need_eff + 2'd1;
    assign bcast_old_tag = wb_old_tag;

    // Recovery resolution: same group, then one step wider, else flush.
    always_comb begin
        bcast_valid   = 1'b0;
        bcast_new_tag = '0;
        flush_req     = 1'b0;
        if (wb_under_valid) begin
            if (grp_found[need_eff]) begin
                bcast_valid   = 1'b1;
                bcast_new_tag = grp_idx[need_eff];
            end else if (need_eff != 2'(GRP_WIDE) && grp_found[need_up]) begin
                bcast_valid   = 1'b1;
                bcast_new_tag = grp_idx[need_up];
            end else begin
                flush_req = 1'b1;
            end
        end
    end

    // Request resolution; a recovery in the same cycle blocks the request.
    always_comb begin
        grant_valid = 1'b0;
        grant_tag   = '0;
        grant_grp   = 2'(GRP_NARROW);
        req_stall   = 1'b0;
        miss_valid  = 1'b0;
        miss_grp    = req_eff;
        if (req_valid) begin
            if (wb_under_valid) begin
                req_stall = 1'b1;
            end else if (grp_found[req_eff]) begin
                grant_valid = 1'b1;
                grant_tag   = grp_idx[req_eff];
                grant_grp   = req_eff;
            end else begin
                miss_valid = 1'b1;
                if (!stall_mode) begin
                    for (int g = NUM_GRP - 1; g >= 1; g--) begin
                        if (g > int'(req_eff) && grp_found[g]) begin
                            grant_valid = 1'b1;
                            grant_tag   = grp_idx[g];
                            grant_grp   = 2'(g);
                        end
                    end
                end
                req_stall = !grant_valid;
            end
        end
    end

    // Free-state update: one take (grant or replacement), commit release and
    // the replaced old tag as returns.
    wgra_free_vec #(.NUM_REGS(NUM_REGS)) u_free (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_valid  (grant_valid | bcast_valid),
        .take_idx    (grant_valid ? grant_tag : bcast_new_tag),
        .ret_a_valid (rel_valid),
        .ret_a_idx   (rel_tag),
        .ret_b_valid (bcast_valid),
        .ret_b_idx   (wb_old_tag),
        .free        (free)
    );
endmodule

// File: rtl/wgra_alloc_checker.sv
// Module: property checker for wgra_alloc, attached by bind. Observes ports only.
module wgra_alloc_checker #(
    parameter int unsigned NUM_REGS = 256,
    localparam int unsigned IW      = $clog2(NUM_REGS),
    localparam int unsigned BW      = $clog2(NUM_REGS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stall_mode,
    input logic [BW-1:0] bound_lo,
    input logic [BW-1:0] bound_hi,
    input logic          req_valid,
    input logic [1:0]    req_grp,
    input logic          grant_valid,
    input logic [IW-1:0] grant_tag,
    input logic [1:0]    grant_grp,
    input logic          req_stall,
    input logic          miss_valid,
    input logic [1:0]    miss_grp,
    input logic          wb_under_valid,
    input logic [IW-1:0] wb_old_tag,
    input logic [1:0]    wb_need_grp,
    input logic          bcast_valid,
    input logic [IW-1:0] bcast_old_tag,
    input logic [IW-1:0] bcast_new_tag,
    input logic          flush_req,
    input logic          rel_valid,
    input logic [IW-1:0] rel_tag
);
    logic [1:0] req_c, need_c, grant_tag_grp, new_tag_grp;

    // Group that an index falls into under the current boundaries.
    function automatic logic [1:0] grp_of(input logic [IW-1:0] t,
                                          input logic [BW-1:0] lo,
                                          input logic [BW-1:0] hi);
        if (BW'(t) < lo)      return 2'd0;
        else if (BW'(t) < hi) return 2'd1;
        else                  return 2'd2;
    endfunction

    assign req_c         = (req_grp == 2'd3) ? 2'd2 : req_grp;
    assign need_c        = (wb_need_grp == 2'd3) ? 2'd2 : wb_need_grp;
    assign grant_tag_grp = grp_of(grant_tag, bound_lo, bound_hi);
    assign new_tag_grp   = grp_of(bcast_new_tag, bound_lo, bound_hi);

    AST_GRANT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> grant_tag_grp == grant_grp); // R2
    AST_GRANT_NOT_NARROWER: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> grant_grp >= req_c); // R3
    AST_SPILL_RAISES_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_grp != req_c) |-> (miss_valid && miss_grp == req_c)); // R3
    AST_STALL_MODE_NO_SPILL: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_mode && grant_valid) |-> grant_grp == req_c); // R4
    AST_REFUSED_REQ_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !grant_valid) |-> req_stall); // R5
    AST_BCAST_GROUP_OK: assert property (@(posedge clk) disable iff (!rst_n)
        bcast_valid |-> (new_tag_grp == need_c || new_tag_grp == need_c + 2'd1)); // R6
    AST_FLUSH_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush_req && bcast_valid)); // R8
    AST_RECOVERY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        wb_under_valid |-> (!grant_valid && !miss_valid)); // R9
    AST_NO_REGRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !(rel_valid && rel_tag == grant_tag))
        |=> !(grant_valid && grant_tag == $past(grant_tag))); // R10
endmodule

bind wgra_alloc wgra_alloc_checker #(.NUM_REGS(NUM_REGS)) u_chk (.*);

// File: tb/wgra_alloc_test.sv
// Directed bench for wgra_alloc. Boundaries 4 and 8: group 0 = 0..3,
// group 1 = 4..7, group 2 = 8..255.
module wgra_alloc_test;
    localparam int unsigned NUM_REGS = 256;
    localparam int unsigned IW = $clog2(NUM_REGS);
    localparam int unsigned BW = $clog2(NUM_REGS + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stall_mode = 1'b0;
    logic [BW-1:0] bound_lo = BW'(4);
    logic [BW-1:0] bound_hi = BW'(8);
    logic          req_valid = 1'b0;
    logic [1:0]    req_grp = 2'd0;
    logic          grant_valid;
    logic [IW-1:0] grant_tag;
    logic [1:0]    grant_grp;
    logic          req_stall;
    logic          miss_valid;
    logic [1:0]    miss_grp;
    logic          wb_under_valid = 1'b0;
    logic [IW-1:0] wb_old_tag = '0;
    logic [1:0]    wb_need_grp = 2'd0;
    logic          bcast_valid;
    logic [IW-1:0] bcast_old_tag;
    logic [IW-1:0] bcast_new_tag;
    logic          flush_req;
    logic          rel_valid = 1'b0;
    logic [IW-1:0] rel_tag = '0;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    wgra_alloc #(.NUM_REGS(NUM_REGS)) uut (.*);

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic idle();
        req_valid = 1'b0; wb_under_valid = 1'b0; rel_valid = 1'b0;
    endtask

    // Let the edge commit the presented inputs, then clear them.
    task automatic tick();
        @(posedge clk); #1; idle(); @(negedge clk);
    endtask

    task automatic req_ok(input int g, input int tag, input int ggrp, input int miss, input string rq);
        req_valid = 1'b1; req_grp = 2'(g); #1;
        chk({rq, " grant_valid"}, int'(grant_valid), 1);
        chk({rq, " grant_tag"},   int'(grant_tag), tag);
        chk({rq, " grant_grp"},   int'(grant_grp), ggrp);
        chk({rq, " miss_valid"},  int'(miss_valid), miss);
        if (miss != 0) chk({rq, " miss_grp"}, int'(miss_grp), g);
        tick();
    endtask

    task automatic req_refused(input int g, input string rq);
        req_valid = 1'b1; req_grp = 2'(g); #1;
        chk({rq, " grant_valid"}, int'(grant_valid), 0);
        chk({rq, " req_stall"},   int'(req_stall), 1);
        chk({rq, " miss_valid"},  int'(miss_valid), 1);
        chk({rq, " miss_grp"},    int'(miss_grp), g);
        tick();
    endtask

    task automatic recover_ok(input int old, input int need, input int new_tag, input string rq);
        wb_under_valid = 1'b1; wb_old_tag = IW'(old); wb_need_grp = 2'(need); #1;
        chk({rq, " bcast_valid"},   int'(bcast_valid), 1);
        chk({rq, " bcast_new_tag"}, int'(bcast_new_tag), new_tag);
        chk({rq, " bcast_old_tag"}, int'(bcast_old_tag), old);
        chk({rq, " flush_req"},     int'(flush_req), 0);
        tick();
    endtask

    task automatic recover_flush(input int old, input int need, input string rq);
        wb_under_valid = 1'b1; wb_old_tag = IW'(old); wb_need_grp = 2'(need); #1;
        chk({rq, " flush_req"},   int'(flush_req), 1);
        chk({rq, " bcast_valid"}, int'(bcast_valid), 0);
        tick();
    endtask

    task automatic release_tag(input int t);
        rel_valid = 1'b1; rel_tag = IW'(t); tick();
    endtask

    // R1: quiet outputs after reset, then the first grant is index 0.
    task automatic t_reset();
        #1;
        chk("R1 grant_valid", int'(grant_valid), 0);
        chk("R1 bcast_valid", int'(bcast_valid), 0);
        chk("R1 flush_req",   int'(flush_req), 0);
        chk("R1 miss_valid",  int'(miss_valid), 0);
        req_ok(0, 0, 0, 0, "R1 first narrow grant");
    endtask

    // R2: lowest-first within the group; R3: spill to mid then skip to wide.
    task automatic t_in_group_and_spill();
        req_ok(0, 1, 0, 0, "R2 narrow");
        req_ok(0, 2, 0, 0, "R2 narrow");
        req_ok(0, 3, 0, 0, "R2 narrow");
        req_ok(3, 8, 2, 0, "R2 code3 as wide");
        req_ok(0, 4, 1, 1, "R3 spill narrow to mid");
    endtask

    // R4: stall mode refuses instead of spilling.
    task automatic t_stall_mode();
        stall_mode = 1'b1;
        req_refused(0, "R4 stall mode");
        stall_mode = 1'b0;
        req_ok(1, 5, 1, 0, "R2 mid");
        req_ok(1, 6, 1, 0, "R2 mid");
        req_ok(1, 7, 1, 0, "R2 mid");
        req_ok(0, 9, 2, 1, "R3 spill narrow past full mid");
    endtask

    // R10 single release; R6/R7 recovery to next wider, old tag freed.
    task automatic t_recover_wider();
        release_tag(2);
        req_ok(0, 2, 0, 0, "R10 released tag reused");
        recover_ok(2, 1, 10, "R6 mid full, wide used");
        req_ok(0, 2, 0, 0, "R7 old tag freed");
        release_tag(5);
        recover_ok(0, 1, 5, "R6 same group first");
        req_ok(0, 0, 0, 0, "R7 old tag freed");
    endtask

    // R9: recovery wins over a request in the same cycle.
    task automatic t_priority();
        wb_under_valid = 1'b1; wb_old_tag = IW'(1); wb_need_grp = 2'd2;
        req_valid = 1'b1; req_grp = 2'd0; #1;
        chk("R9 grant_valid", int'(grant_valid), 0);
        chk("R9 req_stall",   int'(req_stall), 1);
        chk("R9 miss_valid",  int'(miss_valid), 0);
        chk("R9 bcast_new_tag", int'(bcast_new_tag), 11);
        tick();
        req_ok(0, 1, 0, 0, "R9 request retried");
    endtask

    // R8: narrow and mid full, wide free: still a flush, nothing changes.
    task automatic t_flush_two_steps();
        recover_flush(3, 0, "R8 no two-step search");
        req_ok(0, 12, 2, 1, "R8 old tag kept, state unchanged");
    endtask

    // R5/R11 with the wide group exhausted; R10 consecutive releases.
    task automatic t_exhaust();
        for (int t = 13; t < NUM_REGS; t++) begin
            req_valid = 1'b1; req_grp = 2'd2; #1;
            if (grant_tag != IW'(t) || !grant_valid)
                chk("R2 wide fill", int'(grant_tag), t);
            tick();
        end
        chk("R2 wide fill done", 1, 1);
        req_refused(2, "R5 all full");
        req_refused(0, "R5 narrow with all full");
        recover_flush(3, 2, "R11 wide need, wide full");
        recover_flush(3, 1, "R8 mid need, all full");
        rel_valid = 1'b1; rel_tag = IW'(200); @(posedge clk); #1;
        rel_tag = IW'(100); tick();
        req_ok(2, 100, 2, 0, "R10 consecutive release first");
        req_ok(2, 200, 2, 0, "R10 consecutive release second");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_in_group_and_spill();
        t_stall_mode();
        t_recover_wider();
        t_priority();
        t_flush_two_steps();
        t_exhaust();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule